// File: doc/BRIEF.md
# Forward Euler Stepper for y'' + 3xy' + 3y = 0

This block integrates the second-order equation y'' + 3*x*y' + 3*y = 0 by the forward Euler method, in signed fixed point. The equation is split into the slope u = y' and the value y. A caller presents an initial y, an initial slope u, a step size and an upper limit for x, and pulses `start`. The block then steps from x = 0 until x reaches the limit. After every step it shows the new x, y and u, and it raises `done` when the run ends.

A single datapath does the work. It has one or two shared arithmetic lanes, and each lane can add, subtract, multiply or compare. A static schedule feeds the lanes. The parameter `LANES` picks one operation per clock (nine slots per step) or two operations per clock (five slots per step). The results are bit-identical in both modes.

The control is a three-state machine:
- IDLE waits for `start`. A start moves it to COMPUTE (transition *launch*).
- COMPUTE walks the schedule slots. After the last slot it moves to COMMIT (transition *slots_done*).
- COMMIT copies the new x, u and y into the state all at once. It then returns to COMPUTE (transition *next_step*) or, when the new x is at or above the limit, to IDLE (transition *finish*).

Top module: `euler_stepper`

## Requirements
- R1: All values are signed Q8.16 (24 bits, 16 fraction bits). One step computes u' = u - dx*(3*(x*u + y)), y' = y + u*dx and x' = x + dx, using only the values from before the step. The product x*u is formed first, y is added, the sum is multiplied by 3.0, and that result is multiplied by dx.
- R2: Each product is the full product shifted right arithmetically by 16 (truncation toward minus infinity) and then saturated. Each sum or difference is saturated to the raw range -8388608 to 8388607.
- R3: `x_out`, `y_out` and `u_out` change only in the cycle where `step_valid` is high, or in the cycle after an accepted start.
- R4: An accepted start (`start` high while idle) sets x to 0, y to `y_init` and u to `u_init`, captures `step` and `limit`, and clears `done`.
- R5: The run ends after the first step whose new x is at or above `limit` (signed compare). `done` rises in the same cycle as that step's `step_valid`. At least one step is always taken.
- R6: `step_valid` comes every NSLOT+1 cycles, where NSLOT is 9 with one lane and 5 with two lanes. The first `step_valid` comes NSLOT+2 cycles after the cycle in which the start was sampled.
- R7: The two-lane mode yields the same x, y and u, bit for bit, as the one-lane mode.
- R8: `step_valid` is a single-cycle pulse.
- R9: A `start` pulse during a run is ignored. The run's results and its input values are unaffected.
- R10: After `done`, the outputs and `done` hold steady until the next accepted start.
- R11: After reset, `x_out`, `y_out`, `u_out` and `step_valid` are 0 and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; honoured only while idle |
| y_init | input | W | Initial y, Q8.16 |
| u_init | input | W | Initial slope u, Q8.16 |
| step | input | W | Step size dx, Q8.16, positive |
| limit | input | W | Upper bound a of x, Q8.16 |
| x_out | output | W | Current x |
| y_out | output | W | Current y |
| u_out | output | W | Current u |
| step_valid | output | 1 | Pulse: a step just completed |
| done | output | 1 | Run finished; held until the next start |

## Verification
The assertions check the following on every cycle: the fixed step period counted from start and from each step, the single-cycle step pulse, that `done` rises only together with a step, that the outputs change only at steps or at a start, and that the outputs hold while the block sits finished. Only the bench scenarios can show the numerical results. These include truncated products, saturated sums, the stop condition at a limit equal to a multiple of dx or at zero, saturation of x at full scale, a start ignored mid-run, and the bitwise match between the two scheduling modes.

// File: rtl/euler_pkg.sv
package euler_pkg;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_ADD,
        OP_SUB,
        OP_MUL,
        OP_GE
    } op_e;

    typedef enum logic [3:0] {
        SRC_X,
        SRC_U,
        SRC_Y,
        SRC_DX,
        SRC_LIM,
        SRC_THREE,
        SRC_T0,
        SRC_T1,
        SRC_T2,
        SRC_T3
    } src_e;

    typedef enum logic [2:0] {
        DST_NONE,
        DST_T0,
        DST_T1,
        DST_T2,
        DST_T3,
        DST_FLAG
    } dst_e;

    typedef struct packed {
        op_e  op;
        src_e a;
        src_e b;
        dst_e d;
    } uop_t;

    localparam uop_t UOP_IDLE = '{op: OP_NOP, a: SRC_X, b: SRC_X, d: DST_NONE};

    function automatic uop_t mk(op_e op, src_e a, src_e b, dst_e d);
        uop_t r;
        r.op = op;
        r.a  = a;
        r.b  = b;
        r.d  = d;
        return r;
    endfunction

    // Scheduled micro-operations; the index of each one is its position
    // in the dependency chain.
    function automatic uop_t micro(int idx);
        uop_t r;
        case (idx)
            0: r = mk(OP_MUL, SRC_X,  SRC_U,     DST_T0);   // x*u
            1: r = mk(OP_ADD, SRC_T0, SRC_Y,     DST_T0);   // + y
            2: r = mk(OP_MUL, SRC_T0, SRC_THREE, DST_T0);   // * 3
            3: r = mk(OP_MUL, SRC_DX, SRC_T0,    DST_T0);   // * dx
            4: r = mk(OP_SUB, SRC_U,  SRC_T0,    DST_T1);   // new u
            5: r = mk(OP_MUL, SRC_U,  SRC_DX,    DST_T2);   // u*dx
            6: r = mk(OP_ADD, SRC_Y,  SRC_T2,    DST_T2);   // new y
            7: r = mk(OP_ADD, SRC_X,  SRC_DX,    DST_T3);   // new x
            8: r = mk(OP_GE,  SRC_T3, SRC_LIM,   DST_FLAG); // end test
            default: r = UOP_IDLE;
        endcase
        return r;
    endfunction

    // One operation per slot: the chain in order.
    function automatic uop_t prog_single(int slot);
        return micro(slot);
    endfunction

    // Two operations per slot: lane 0 runs the u chain, lane 1 runs the
    // y update followed by the x update and the compare.
    function automatic uop_t prog_dual(int slot, int lane);
        uop_t r;
        if (lane == 0) begin
            r = (slot <= 4) ? micro(slot) : UOP_IDLE;
        end else begin
            r = (slot <= 3) ? micro(slot + 5) : UOP_IDLE;
        end
        return r;
    endfunction

endpackage

// File: rtl/euler_alu.sv
module euler_alu
    import euler_pkg::*;
#(
    parameter int W    = 24,
    parameter int FRAC = 16
) (
    input  op_e                 op,
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] res,
    output logic                ge
);
    localparam int WW = 2 * W;
    localparam logic signed [WW-1:0] HI = {{(W + 1){1'b0}}, {(W - 1){1'b1}}};
    localparam logic signed [WW-1:0] LO = {{(W + 1){1'b1}}, {(W - 1){1'b0}}};

    logic signed [WW-1:0] ea, eb, wide;

    assign ea = {{W{a[W-1]}}, a};
    assign eb = {{W{b[W-1]}}, b};
    assign ge = (a >= b);

    always_comb begin
        unique case (op)
            OP_ADD:  wide = ea + eb;
            OP_SUB:  wide = ea - eb;
            OP_MUL:  wide = (ea * eb) >>> FRAC;
            default: wide = '0;
        endcase
        if (wide > HI)      res = HI[W-1:0];
        else if (wide < LO) res = LO[W-1:0];
        else                res = wide[W-1:0];
    end
endmodule

// File: rtl/euler_sched.sv
module euler_sched
    import euler_pkg::*;
#(
    parameter int LANES = 1,
    parameter int SW    = 4
) (
    input  logic [SW-1:0] slot,
    output uop_t          uops [LANES]
);
    generate
        if (LANES == 1) begin : g_single
            always_comb uops[0] = prog_single(int'(slot));
        end else begin : g_dual
            for (genvar l = 0; l < LANES; l++) begin : g_lane
                always_comb uops[l] = prog_dual(int'(slot), l);
            end
        end
    endgenerate
endmodule

// File: rtl/euler_stepper.sv
module euler_stepper
    import euler_pkg::*;
#(
    parameter int LANES = 1,
    parameter int W     = 24,
    parameter int FRAC  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic signed [W-1:0] y_init,
    input  logic signed [W-1:0] u_init,
    input  logic signed [W-1:0] step,
    input  logic signed [W-1:0] limit,
    output logic signed [W-1:0] x_out,
    output logic signed [W-1:0] y_out,
    output logic signed [W-1:0] u_out,
    output logic                step_valid,
    output logic                done
);
    localparam int NSLOT = (LANES == 1) ? 9 : 5;
    localparam int SW    = $clog2(NSLOT + 1);
    localparam int NTMP  = 4;
    localparam logic signed [W-1:0] THREE = W'(3) <<< FRAC;

    typedef enum logic [1:0] {ST_IDLE, ST_COMPUTE, ST_COMMIT} state_e;

    state_e state, state_nx;
    logic [SW-1:0] slot;
    logic signed [W-1:0] dx_q, lim_q;
    logic signed [W-1:0] tmp [NTMP];
    logic flag;
    logic running;

    uop_t uops [LANES];
    logic signed [W-1:0] opa [LANES];
    logic signed [W-1:0] opb [LANES];
    logic signed [W-1:0] res [LANES];
    logic                ge  [LANES];

    assign running = (state != ST_IDLE);

    euler_sched #(.LANES(LANES), .SW(SW)) u_sched (
        .slot (slot),
        .uops (uops)
    );

    function automatic logic signed [W-1:0] pick(
        src_e s, logic signed [W-1:0] xv, logic signed [W-1:0] uv,
        logic signed [W-1:0] yv, logic signed [W-1:0] dv,
        logic signed [W-1:0] lv, logic signed [W-1:0] t0,
        logic signed [W-1:0] t1, logic signed [W-1:0] t2,
        logic signed [W-1:0] t3);
        logic signed [W-1:0] r;
        unique case (s)
            SRC_X:     r = xv;
            SRC_U:     r = uv;
            SRC_Y:     r = yv;
            SRC_DX:    r = dv;
            SRC_LIM:   r = lv;
            SRC_THREE: r = THREE;
            SRC_T0:    r = t0;
            SRC_T1:    r = t1;
            SRC_T2:    r = t2;
            SRC_T3:    r = t3;
            default:   r = '0;
        endcase
        return r;
    endfunction

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            always_comb begin
                opa[g] = pick(uops[g].a, x_out, u_out, y_out, dx_q, lim_q,
                              tmp[0], tmp[1], tmp[2], tmp[3]);
                opb[g] = pick(uops[g].b, x_out, u_out, y_out, dx_q, lim_q,
                              tmp[0], tmp[1], tmp[2], tmp[3]);
            end
            euler_alu #(.W(W), .FRAC(FRAC)) u_alu (
                .op  (uops[g].op),
                .a   (opa[g]),
                .b   (opb[g]),
                .res (res[g]),
                .ge  (ge[g])
            );
        end
    endgenerate

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: launch, slots_done, next_step, finish
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_COMPUTE;
            ST_COMPUTE: if (slot == SW'(NSLOT - 1)) state_nx = ST_COMMIT;
            ST_COMMIT:  state_nx = flag ? ST_IDLE : ST_COMPUTE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_out      <= '0;
            y_out      <= '0;
            u_out      <= '0;
            dx_q       <= '0;
            lim_q      <= '0;
            step_valid <= 1'b0;
            done       <= 1'b0;
            flag       <= 1'b0;
            slot       <= '0;
            for (int i = 0; i < NTMP; i++) tmp[i] <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    step_valid <= 1'b0;
                    slot       <= '0;
                    if (start) begin
                        x_out <= '0;
                        y_out <= y_init;
                        u_out <= u_init;
                        dx_q  <= step;
                        lim_q <= limit;
                        done  <= 1'b0;
                        flag  <= 1'b0;
                    end
                end
                ST_COMPUTE: begin
                    step_valid <= 1'b0;
                    slot       <= slot + 1'b1;
                    for (int l = 0; l < LANES; l++) begin
                        unique case (uops[l].d)
                            DST_T0:   tmp[0] <= res[l];
                            DST_T1:   tmp[1] <= res[l];
                            DST_T2:   tmp[2] <= res[l];
                            DST_T3:   tmp[3] <= res[l];
                            DST_FLAG: flag   <= ge[l];
                            default:  ;
                        endcase
                    end
                end
                ST_COMMIT: begin
                    x_out      <= tmp[3];
                    u_out      <= tmp[1];
                    y_out      <= tmp[2];
                    step_valid <= 1'b1;
                    slot       <= '0;
                    if (flag) done <= 1'b1;
                end
                default: step_valid <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/euler_stepper_chk.sv
module euler_stepper_chk #(
    parameter int NSLOT = 9,
    parameter int W     = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         running,
    input logic         step_valid,
    input logic         done,
    input logic [W-1:0] x_out,
    input logic [W-1:0] y_out,
    input logic [W-1:0] u_out
);
    logic [7:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 gap <= '0;
        else if (start && !running) gap <= 8'd0;
        else if (step_valid)        gap <= 8'd1;
        else if (gap != 8'hFF)      gap <= gap + 8'd1;
    end

    a_r6_step_period: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> (gap == 8'(NSLOT + 1)));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |=> !step_valid);

    a_r5_done_with_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> step_valid);

    a_r10_hold_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> ($stable(x_out) && $stable(y_out) && $stable(u_out)));

    a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !running) |=> (x_out == '0 && !done));

    a_r3_change_only_at_step: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(x_out) && $stable(y_out) && $stable(u_out))
            |-> (step_valid || $past(start && !running)));
endmodule

bind euler_stepper euler_stepper_chk #(.NSLOT(NSLOT), .W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .running    (running),
    .step_valid (step_valid),
    .done       (done),
    .x_out      (x_out),
    .y_out      (y_out),
    .u_out      (u_out)
);

// File: tb/euler_stepper_test.sv
module euler_stepper_test;
    localparam int W = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start1 = 1'b0, start2 = 1'b0;
    logic signed [W-1:0] y_init = '0, u_init = '0, step = '0, limit = '0;
    logic signed [W-1:0] x1, y1, u1, x2, y2, u2;
    logic sv1, sv2, d1, d2;

    int checks = 0;
    int fails  = 0;
    longint fin [2][6][3];

    always #2 clk = ~clk;

    euler_stepper #(.LANES(1)) uut (
        .clk(clk), .rst_n(rst_n), .start(start1), .y_init(y_init),
        .u_init(u_init), .step(step), .limit(limit), .x_out(x1),
        .y_out(y1), .u_out(u1), .step_valid(sv1), .done(d1));

    euler_stepper #(.LANES(2)) uut_dual (
        .clk(clk), .rst_n(rst_n), .start(start2), .y_init(y_init),
        .u_init(u_init), .step(step), .limit(limit), .x_out(x2),
        .y_out(y2), .u_out(u2), .step_valid(sv2), .done(d2));

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint satv(longint v);
        if (v > 64'sd8388607)  return 64'sd8388607;
        if (v < -64'sd8388608) return -64'sd8388608;
        return v;
    endfunction

    function automatic longint mulq(longint a, longint b);
        return satv((a * b) >>> 16);
    endfunction

    task automatic pulse_start(int mode);
        if (mode == 0) start1 = 1'b1; else start2 = 1'b1;
        @(negedge clk);
        start1 = 1'b0;
        start2 = 1'b0;
    endtask

    task automatic run(int mode, int sc, longint y0, longint u0, longint dx,
                       longint lim, bit poke);
        longint ex = 0, ey = y0, eu = u0, t, nx, ny, nu;
        int gap, steps = 0, cyc = 0;
        bit edone = 0, poked = 0, fin_seen = 0;
        int nslot = (mode == 0) ? 9 : 5;
        longint ax, ay, au;
        bit asv, ad;
        @(negedge clk);
        y_init = W'(y0); u_init = W'(u0); step = W'(dx); limit = W'(lim);
        pulse_start(mode);
        gap = 1;
        // R4: state loaded at launch
        ax = (mode == 0) ? longint'(x1) : longint'(x2);
        ay = (mode == 0) ? longint'(y1) : longint'(y2);
        ad = (mode == 0) ? d1 : d2;
        check(ax == 0 && ay == y0 && !ad, "R4", "launch x/y/done", ax, 0);
        while (!fin_seen) begin
            @(negedge clk);
            gap++;
            cyc++;
            start1 = 1'b0;
            start2 = 1'b0;
            if (poke && steps == 2 && !poked) begin
                // R9: disturb inputs and pulse start mid-run
                y_init = 24'sh123456; u_init = -24'sd99; step = 24'sd1; limit = 24'sd7;
                if (mode == 0) start1 = 1'b1; else start2 = 1'b1;
                poked = 1;
            end
            ax  = (mode == 0) ? longint'(x1) : longint'(x2);
            ay  = (mode == 0) ? longint'(y1) : longint'(y2);
            au  = (mode == 0) ? longint'(u1) : longint'(u2);
            asv = (mode == 0) ? sv1 : sv2;
            ad  = (mode == 0) ? d1 : d2;
            if (asv) begin
                t  = mulq(ex, eu);
                t  = satv(t + ey);
                t  = mulq(t, 64'sd196608);
                t  = mulq(dx, t);
                nu = satv(eu - t);
                ny = satv(ey + mulq(eu, dx));
                nx = satv(ex + dx);
                ex = nx; ey = ny; eu = nu;
                edone = (nx >= lim);
                steps++;
                check(ax == ex, poke ? "R9" : "R1", "x", ax, ex);
                check(ay == ey, "R2", "y", ay, ey);
                check(au == eu, "R1", "u", au, eu);
                check(gap == ((steps == 1) ? nslot + 2 : nslot + 1), "R6",
                      "step period", gap, (steps == 1) ? nslot + 2 : nslot + 1);
                check(ad == edone, "R5", "done at step", ad, edone);
                gap = 0;
                if (edone) fin_seen = 1;
            end
            if (cyc > 5000) begin
                check(0, "R5", "run never ended", steps, 0);
                fin_seen = 1;
            end
        end
        // R8: the pulse is gone one cycle later
        @(negedge clk);
        asv = (mode == 0) ? sv1 : sv2;
        check(!asv, "R8", "step_valid width", asv, 0);
        // R10: outputs hold while finished
        repeat (15) @(negedge clk);
        check(((mode == 0) ? d1 : d2) == 1'b1, "R10", "done held", 0, 1);
        check(((mode == 0) ? longint'(x1) : longint'(x2)) == ex, "R10", "x held",
              (mode == 0) ? longint'(x1) : longint'(x2), ex);
        check(((mode == 0) ? longint'(y1) : longint'(y2)) == ey, "R3", "y held",
              (mode == 0) ? longint'(y1) : longint'(y2), ey);
        fin[mode][sc][0] = (mode == 0) ? longint'(x1) : longint'(x2);
        fin[mode][sc][1] = (mode == 0) ? longint'(y1) : longint'(y2);
        fin[mode][sc][2] = (mode == 0) ? longint'(u1) : longint'(u2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(x1 == 0 && y1 == 0 && u1 == 0 && !sv1 && !d1, "R11", "reset single", x1, 0);
        check(x2 == 0 && y2 == 0 && u2 == 0 && !sv2 && !d2, "R11", "reset dual", x2, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            run(m, 0, 65536, 0, 16384, 131072, 0);
            run(m, 1, 32768, -65536, 6554, 65536, 1);
            run(m, 2, -131072, 196608, 4096, 131072, 0);
            run(m, 3, 65536, 65536, 16384, 0, 0);
            run(m, 4, 6553600, 6553600, 3932160, 8388607, 0);
            run(m, 5, -65536, 32768, 32768, 65536, 0);
        end
        for (int s = 0; s < 6; s++) begin
            for (int k = 0; k < 3; k++) begin
                check(fin[0][s][k] == fin[1][s][k], "R7", "mode match",
                      fin[1][s][k], fin[0][s][k]);
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule